// File: doc/BRIEF.md
# Privilege-Gated Interrupt Priority Selector

This block keeps one pending flag for each of seven interrupt sources. It decides, from the current privilege level and the global interrupt-enable bit, whether the processor may take an interrupt now. When it may, the block also names the one source to service first.

Each source has a one-cycle set pulse and a one-cycle clear pulse, and these update the pending flags on the next rising clock edge. The hyperprivilege bit and the enable bit are plain level inputs. They feed a purely combinational selector, so a mode change shows on the outputs in the same cycle.

In hyperprivileged mode only the hypervisor interrupt and the interrupt vector can win, and only while interrupts are enabled. In the lower privilege modes, three sources always compete: the trap-level-zero event, the hypervisor interrupt and the interrupt vector. The four remaining sources join them only while interrupts are enabled.

Top module: `intr_sel_top`

## Requirements
- R1: A synchronous active-high reset clears every pending flag. After reset, `takeIntr` is 0 and `srcId` is 7 in every mode.
- R2: Source codes are 0 trap-level-zero, 1 hypervisor interrupt, 2 interrupt vector, 3 cross-CPU message, 4 device message, 5 software interrupt, 6 resumable error and 7 none. Bit i of `setPulse` and bit i of `clrPulse` belong to the source with code i.
- R3: With no flag pending, `takeIntr` is 0 and `srcId` is 7.
- R4: With `hyperMode`=1 and `intEnable`=0, nothing is taken, whatever is pending.
- R5: With `hyperMode`=1 and `intEnable`=1, code 1 beats code 2, and codes 0, 3, 4, 5 and 6 are ignored.
- R6: With `hyperMode`=0, codes 0, 1 and 2 are eligible in that priority order, whatever the value of `intEnable`.
- R7: With `hyperMode`=0 and `intEnable`=1, codes 3, 4, 5 and 6 follow codes 0 to 2 in that descending priority order.
- R8: With `hyperMode`=0 and `intEnable`=0, codes 3 to 6 are ignored.
- R9: `takeIntr` is 1 exactly when `srcId` is not 7. Whenever `takeIntr` is 1, `srcId` names a flag that is pending and eligible.
- R10: A set pulse or a clear pulse changes its flag at the next rising edge. With no pulse, the flag holds its value.
- R11: When a set pulse and a clear pulse hit the same flag in the same cycle, the flag ends up set.
- R12: A change of `hyperMode` or `intEnable` changes the outputs in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| setPulse | input | 7 | Per-source set pulse, bit index = source code |
| clrPulse | input | 7 | Per-source clear pulse, bit index = source code |
| hyperMode | input | 1 | 1 = hyperprivileged mode |
| intEnable | input | 1 | Global interrupt enable |
| takeIntr | output | 1 | An eligible interrupt is pending |
| srcId | output | 3 | Code of the selected source, 7 when none |

## Verification
The selector is first tried with all seven flags pending. The flags are then cleared one at a time, from the highest priority down. Each clear exposes the next winner, which pins down the full order in each of the three mode and enable combinations.

With everything pending, hyperprivileged mode with the enable bit clear must still report nothing. This separates masking by mode from masking by enable. Toggling the mode bits between clock edges shows that the selection has no latency.

A simultaneous set and clear on one flag, followed by a lone clear, separates set-wins from clear-wins and shows the flag hold between pulses.

// File: rtl/intr_sel_pkg.sv
package intr_sel_pkg;
  localparam int NUM_SRC = 7;
  localparam int ID_W = $clog2(NUM_SRC + 1);

  typedef enum logic [ID_W-1:0] {
    SRC_LVL0 = 3'd0,
    SRC_HYP  = 3'd1,
    SRC_VEC  = 3'd2,
    SRC_CPU  = 3'd3,
    SRC_DEV  = 3'd4,
    SRC_SOFT = 3'd5,
    SRC_RERR = 3'd6,
    SRC_NONE = 3'd7
  } srcCode_e;

  // Sources eligible in hyperprivileged mode while enabled
  localparam logic [NUM_SRC-1:0] HYP_MASK    = 7'b000_0110;
  // Sources eligible in lower modes regardless of enable
  localparam logic [NUM_SRC-1:0] ALWAYS_MASK = 7'b000_0111;
  // Sources eligible in lower modes only while enabled
  localparam logic [NUM_SRC-1:0] GATED_MASK  = 7'b111_1000;

  typedef struct packed {
    logic [NUM_SRC-1:0] loadEn;
    logic [NUM_SRC-1:0] loadVal;
  } pendStrobe_t;
endpackage

// File: rtl/intr_sel_ctl.sv
module intr_sel_ctl
  import intr_sel_pkg::*;
(
  input  logic [NUM_SRC-1:0] setPulse,
  input  logic [NUM_SRC-1:0] clrPulse,
  output pendStrobe_t        strobe
);
  // Set has priority: loading the set bit makes a concurrent clear lose.
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_strobe
    assign strobe.loadEn[i]  = setPulse[i] | clrPulse[i];
    assign strobe.loadVal[i] = setPulse[i];
  end
endmodule

// File: rtl/intr_sel_pend.sv
module intr_sel_pend
  import intr_sel_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  pendStrobe_t        strobe,
  output logic [NUM_SRC-1:0] pendQ
);
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flop
    always_ff @(posedge clk) begin
      if (rst)
        pendQ[i] <= 1'b0;
      else if (strobe.loadEn[i])
        pendQ[i] <= strobe.loadVal[i];
    end
  end
endmodule

// File: rtl/intr_sel_pick.sv
module intr_sel_pick
  import intr_sel_pkg::*;
(
  input  logic [NUM_SRC-1:0] pendQ,
  input  logic               hyperMode,
  input  logic               intEnable,
  output logic               takeIntr,
  output logic [ID_W-1:0]    srcId
);
  logic [NUM_SRC-1:0] eligMask;
  logic [NUM_SRC-1:0] candVec;

  always_comb begin
    if (hyperMode)
      eligMask = intEnable ? HYP_MASK : '0;
    else
      eligMask = ALWAYS_MASK | (intEnable ? GATED_MASK : '0);
  end

  assign candVec = pendQ & eligMask;

  // Code order equals priority order, so the lowest set index wins.
  always_comb begin
    srcId = SRC_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (candVec[i]) srcId = ID_W'(i);
    end
  end

  assign takeIntr = |candVec;
endmodule

// File: rtl/intr_sel_top.sv
module intr_sel_top
  import intr_sel_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  setPulse,
  input  logic [NUM_SRC-1:0]  clrPulse,
  input  logic                hyperMode,
  input  logic                intEnable,
  output logic                takeIntr,
  output logic [ID_W-1:0]     srcId
);
  pendStrobe_t        strobe;
  logic [NUM_SRC-1:0] pendQ;

  intr_sel_ctl u_ctl (
    .setPulse (setPulse),
    .clrPulse (clrPulse),
    .strobe   (strobe)
  );

  intr_sel_pend u_pend (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .pendQ  (pendQ)
  );

  intr_sel_pick u_pick (
    .pendQ     (pendQ),
    .hyperMode (hyperMode),
    .intEnable (intEnable),
    .takeIntr  (takeIntr),
    .srcId     (srcId)
  );
endmodule

// File: rtl/intr_sel_chk.sv
module intr_sel_chk
  import intr_sel_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] setPulse,
  input logic [NUM_SRC-1:0] clrPulse,
  input logic               hyperMode,
  input logic               intEnable,
  input logic [NUM_SRC-1:0] pendQ,
  input logic               takeIntr,
  input logic [ID_W-1:0]    srcId
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (pendQ == '0));

  // R9
  flag_id_chk: assert property (@(posedge clk) disable iff (rst)
    takeIntr |-> (srcId < ID_W'(NUM_SRC)) && pendQ[srcId[ID_W-1:0]]);

  // R9
  idle_id_chk: assert property (@(posedge clk) disable iff (rst)
    !takeIntr |-> (srcId == SRC_NONE));

  // R4
  hyp_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (hyperMode && !intEnable) |-> !takeIntr);

  // R5
  hyp_src_chk: assert property (@(posedge clk) disable iff (rst)
    (hyperMode && takeIntr) |-> (srcId == SRC_HYP || srcId == SRC_VEC));

  // R8
  gated_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!hyperMode && !intEnable && takeIntr) |-> (srcId <= SRC_VEC));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      setPulse[i] |=> pendQ[i]);
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (rst)
      (clrPulse[i] && !setPulse[i]) |=> !pendQ[i]);
  end
endmodule

bind intr_sel_top intr_sel_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .setPulse  (setPulse),
  .clrPulse  (clrPulse),
  .hyperMode (hyperMode),
  .intEnable (intEnable),
  .pendQ     (pendQ),
  .takeIntr  (takeIntr),
  .srcId     (srcId)
);

// File: tb/sim_intr_sel_top.sv
module sim_intr_sel_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] setPulse = '0;
  logic [6:0] clrPulse = '0;
  logic       hyperMode = 1'b0;
  logic       intEnable = 1'b0;
  logic       takeIntr;
  logic [2:0] srcId;
  int nChk = 0;
  int nBad = 0;

  always #10 clk = ~clk;

  intr_sel_top u0 (
    .clk       (clk),
    .rst       (rst),
    .setPulse  (setPulse),
    .clrPulse  (clrPulse),
    .hyperMode (hyperMode),
    .intEnable (intEnable),
    .takeIntr  (takeIntr),
    .srcId     (srcId)
  );

  task automatic check(string tag, logic expTake, logic [2:0] expId);
    nChk++;
    if (takeIntr !== expTake || srcId !== expId) begin
      nBad++;
      $display("FAIL %s: take=%0b id=%0d expected take=%0b id=%0d",
               tag, takeIntr, srcId, expTake, expId);
    end
  endtask

  task automatic pulse(logic [6:0] s, logic [6:0] c);
    @(negedge clk);
    setPulse = s;
    clrPulse = c;
    @(negedge clk);
    setPulse = '0;
    clrPulse = '0;
    #1;
  endtask

  task automatic setMode(logic h, logic e);
    hyperMode = h;
    intEnable = e;
    #1;
  endtask

  task automatic test_reset();
    pulse(7'h7F, 7'h00);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    setMode(1'b0, 1'b1);
    check("R1 reset lower enabled", 1'b0, 3'd7);
    setMode(1'b1, 1'b1);
    check("R1 reset hyper enabled", 1'b0, 3'd7);
    check("R3 nothing pending", 1'b0, 3'd7);
  endtask

  task automatic test_hyper();
    pulse(7'h7F, 7'h00);
    setMode(1'b1, 1'b0);
    check("R4 hyper disabled all pending", 1'b0, 3'd7);
    setMode(1'b1, 1'b1);
    check("R5 R12 hyper enabled picks code 1", 1'b1, 3'd1);
    pulse(7'h00, 7'h02);
    check("R5 R2 hyper vector next", 1'b1, 3'd2);
    pulse(7'h00, 7'h04);
    check("R5 others ignored in hyper", 1'b0, 3'd7);
    pulse(7'h00, 7'h7F);
  endtask

  task automatic test_lower();
    pulse(7'h7F, 7'h00);
    setMode(1'b0, 1'b0);
    check("R6 R12 level zero first", 1'b1, 3'd0);
    pulse(7'h00, 7'h01);
    check("R6 hypervisor second", 1'b1, 3'd1);
    pulse(7'h00, 7'h02);
    check("R6 vector third", 1'b1, 3'd2);
    pulse(7'h00, 7'h04);
    check("R8 gated ignored when disabled", 1'b0, 3'd7);
    setMode(1'b0, 1'b1);
    check("R7 R12 cross-CPU message", 1'b1, 3'd3);
    pulse(7'h00, 7'h08);
    check("R7 device message", 1'b1, 3'd4);
    pulse(7'h00, 7'h10);
    check("R7 software interrupt", 1'b1, 3'd5);
    pulse(7'h00, 7'h20);
    check("R7 R2 resumable error", 1'b1, 3'd6);
    pulse(7'h00, 7'h40);
    check("R3 R9 all cleared", 1'b0, 3'd7);
  endtask

  task automatic test_update();
    setMode(1'b0, 1'b1);
    pulse(7'h20, 7'h20);
    check("R11 set wins over clear", 1'b1, 3'd5);
    repeat (3) @(negedge clk);
    check("R10 flag holds", 1'b1, 3'd5);
    pulse(7'h00, 7'h20);
    check("R10 lone clear", 1'b0, 3'd7);
    pulse(7'h41, 7'h00);
    check("R10 set two flags", 1'b1, 3'd0);
    setMode(1'b1, 1'b1);
    check("R12 hyper drops both", 1'b0, 3'd7);
    setMode(1'b0, 1'b0);
    check("R12 back to lower mode", 1'b1, 3'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 R3 after power-up reset", 1'b0, 3'd7);
    test_reset();
    test_hyper();
    test_lower();
    test_update();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog: run still active after 5000 cycles, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule